// File: doc/BRIEF.md
# D/N/U Triple Buffer Manager

This block hands three equal-sized data buffers around between the bus side of a fieldbus slave and the application that uses the data. Each buffer holds one of three roles at any moment: D is the one the bus side is filling or draining, N holds the newest complete data, and U belongs to the application. Only the 2-bit buffer indices are produced here. The buffer RAM and the logic that zeroes a buffer sit outside the block.

Two independent rotations run side by side. In the output direction, data received from the bus lands in D. An error-free receipt or a clear request publishes D as N. The application then claims N into U with a "next" command, and a registered reply returns the claimed index, or "none" when nothing new is waiting, together with a flag telling whether that buffer came from the clear path. In the input direction, the application publishes its filled U buffer as N. Just before each transmission the bus side fetches a fresh N into D, unless the freeze flag is set.

Buffer indices use the codes 0 = none, 1 = buffer 1, 2 = buffer 2 and 3 = buffer 3.

Top module: `dnu_buffer_mgr`

## Requirements
- R1: After synchronous reset both directions hold D=1, N=2 and U=3. The output direction reports fresh N pending (`out_new`=1), while the input direction reports none (`in_new`=0). `out_reply_vld` and `dout_irq` are 0.
- R2: `rx_done` without `rx_err` or `clr_req` swaps the output D and N indices, sets `out_new`, and pulses `dout_irq` for exactly one cycle, in the cycle after the receipt.
- R3: `rx_err` causes no role change in the output direction and raises no interrupt, even when `rx_done` is high in the same cycle.
- R4: `clr_req` swaps the output D and N indices, sets `out_new` and marks the published buffer as cleared. It takes precedence over `rx_done` and raises no interrupt.
- R5: `out_next` while `out_new`=1 swaps the output U and N indices and clears `out_new`. In the next cycle it gives `out_reply_vld`=1, `out_reply_code` equal to the new U index (1 to 3), and `out_reply_cleared`=1 only when that buffer was published by the clear path.
- R6: `out_next` while `out_new`=0 gives `out_reply_code`=0 (none) and `out_reply_cleared`=0 in the next cycle, and leaves all output indices unchanged.
- R7: `in_next` swaps the input U and N indices and sets `in_new`.
- R8: `fetch` with `freeze`=0 and `in_new`=1 swaps the input D and N indices and clears `in_new`. With `in_new`=0 it changes nothing.
- R9: `fetch` while `freeze`=1 changes no input index and leaves `in_new` as it was.
- R10: When a claim and a publish fall in the same cycle of one direction, the claim acts first on the old N, and the publish then places its buffer in N. Output: U←N, N←D, D←U. Input: D←N, N←U, U←D.
- R11: In each direction the D, N and U indices are always nonzero and pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | Output data receipt finished (pulse) |
| rx_err | input | 1 | Receipt had an error (pulse) |
| clr_req | input | 1 | Clear-data request: power-up, master leave or clear command |
| out_next | input | 1 | Application claims newest output buffer |
| in_next | input | 1 | Application publishes its input buffer |
| fetch | input | 1 | Bus side fetch before sending |
| freeze | input | 1 | Suppress the pre-send fetch |
| out_d_idx | output | 2 | Output direction D index |
| out_n_idx | output | 2 | Output direction N index |
| out_u_idx | output | 2 | Output direction U index |
| out_new | output | 1 | Output N holds unclaimed data |
| out_reply_vld | output | 1 | Reply to `out_next` valid |
| out_reply_code | output | 2 | Claimed index or 0 for none |
| out_reply_cleared | output | 1 | Claimed buffer came from clear path |
| dout_irq | output | 1 | Data-out interrupt pulse |
| in_d_idx | output | 2 | Input direction D index |
| in_n_idx | output | 2 | Input direction N index |
| in_u_idx | output | 2 | Input direction U index |
| in_new | output | 1 | Input N holds unfetched data |

## Verification
The hardest case to reach from the ports is a claim and a publish landing in the same cycle, above all when the claimed buffer came from the clear path. In that cycle the reply has to carry the cleared flag of the old N, while N already holds the buffer just received. Directed steps set this up on purpose: reset leaves a cleared buffer pending, and a later step drives `rx_done` together with `out_next` right after a clear request. A long run of pseudo-random pulses follows, with freeze and error mixed in, and every output is compared against a behavioural model on every cycle.

// File: rtl/dnu_pkg.sv
package dnu_pkg;

    localparam int BUF_CNT = 3;
    localparam int IDX_W   = $clog2(BUF_CNT + 1);

    typedef logic [IDX_W-1:0] buf_id_t;

    localparam buf_id_t BUF_NONE = '0;

    // Role assignment of one direction: producer, middle (newest), consumer
    typedef struct packed {
        buf_id_t p;
        buf_id_t n;
        buf_id_t c;
        logic    fresh;
        logic    wiped;
    } roles_t;

    function automatic roles_t swap_cn(input roles_t r);
        roles_t o;
        o   = r;
        o.c = r.n;
        o.n = r.c;
        return o;
    endfunction

    function automatic roles_t swap_pn(input roles_t r);
        roles_t o;
        o   = r;
        o.p = r.n;
        o.n = r.p;
        return o;
    endfunction

endpackage

// File: rtl/dnu_rotor.sv
module dnu_rotor
    import dnu_pkg::*;
#(
    parameter buf_id_t RST_P     = buf_id_t'(1),
    parameter buf_id_t RST_N     = buf_id_t'(2),
    parameter buf_id_t RST_C     = buf_id_t'(3),
    parameter bit      RST_FRESH = 1'b0,
    parameter bit      RST_WIPED = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    take_req,
    input  logic    publish,
    input  logic    publish_wiped,
    output buf_id_t prod_idx,
    output buf_id_t mid_idx,
    output buf_id_t cons_idx,
    output logic    fresh,
    output logic    take_hit,
    output logic    take_wiped
);

    roles_t cur, nxt;

    always_comb begin
        nxt = cur;
        // claim acts on the old middle buffer first
        if (take_req && cur.fresh) begin
            nxt       = swap_cn(nxt);
            nxt.fresh = 1'b0;
        end
        // publish then places the producer's buffer in the middle
        if (publish) begin
            nxt       = swap_pn(nxt);
            nxt.fresh = 1'b1;
            nxt.wiped = publish_wiped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.p     <= RST_P;
            cur.n     <= RST_N;
            cur.c     <= RST_C;
            cur.fresh <= RST_FRESH;
            cur.wiped <= RST_WIPED;
        end else begin
            cur <= nxt;
        end
    end

    assign prod_idx   = cur.p;
    assign mid_idx    = cur.n;
    assign cons_idx   = cur.c;
    assign fresh      = cur.fresh;
    assign take_hit   = take_req && cur.fresh;
    assign take_wiped = cur.wiped;

endmodule

// File: rtl/dnu_reply.sv
module dnu_reply
    import dnu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    hit,
    input  logic    hit_wiped,
    input  buf_id_t hit_idx,
    input  logic    irq_set,
    output logic    reply_vld,
    output buf_id_t reply_code,
    output logic    reply_cleared,
    output logic    irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_vld     <= 1'b0;
            reply_code    <= BUF_NONE;
            reply_cleared <= 1'b0;
            irq           <= 1'b0;
        end else begin
            reply_vld     <= req;
            reply_code    <= hit ? hit_idx : BUF_NONE;
            reply_cleared <= hit && hit_wiped;
            irq           <= irq_set;
        end
    end

endmodule

// File: rtl/dnu_buffer_mgr.sv
module dnu_buffer_mgr
    import dnu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_done,
    input  logic       rx_err,
    input  logic       clr_req,
    input  logic       out_next,
    input  logic       in_next,
    input  logic       fetch,
    input  logic       freeze,
    output logic [1:0] out_d_idx,
    output logic [1:0] out_n_idx,
    output logic [1:0] out_u_idx,
    output logic       out_new,
    output logic       out_reply_vld,
    output logic [1:0] out_reply_code,
    output logic       out_reply_cleared,
    output logic       dout_irq,
    output logic [1:0] in_d_idx,
    output logic [1:0] in_n_idx,
    output logic [1:0] in_u_idx,
    output logic       in_new
);

    logic    rx_good, out_pub;
    logic    out_hit, out_hit_wiped;
    logic    in_hit_unused, in_wiped_unused;
    buf_id_t o_p, o_n, o_c, i_p, i_n, i_c;

    assign rx_good = rx_done && !rx_err && !clr_req;
    assign out_pub = clr_req || (rx_done && !rx_err);

    // output direction: bus side produces (D), application consumes (U)
    dnu_rotor #(
        .RST_P(buf_id_t'(1)), .RST_N(buf_id_t'(2)), .RST_C(buf_id_t'(3)),
        .RST_FRESH(1'b1), .RST_WIPED(1'b1)
    ) u_out (
        .clk(clk), .rst(rst),
        .take_req(out_next), .publish(out_pub), .publish_wiped(clr_req),
        .prod_idx(o_p), .mid_idx(o_n), .cons_idx(o_c), .fresh(out_new),
        .take_hit(out_hit), .take_wiped(out_hit_wiped)
    );

    // input direction: application produces (U), bus side consumes (D)
    dnu_rotor #(
        .RST_P(buf_id_t'(3)), .RST_N(buf_id_t'(2)), .RST_C(buf_id_t'(1)),
        .RST_FRESH(1'b0), .RST_WIPED(1'b0)
    ) u_in (
        .clk(clk), .rst(rst),
        .take_req(fetch && !freeze), .publish(in_next), .publish_wiped(1'b0),
        .prod_idx(i_p), .mid_idx(i_n), .cons_idx(i_c), .fresh(in_new),
        .take_hit(in_hit_unused), .take_wiped(in_wiped_unused)
    );

    dnu_reply u_reply (
        .clk(clk), .rst(rst),
        .req(out_next), .hit(out_hit), .hit_wiped(out_hit_wiped), .hit_idx(o_n),
        .irq_set(rx_good),
        .reply_vld(out_reply_vld), .reply_code(out_reply_code),
        .reply_cleared(out_reply_cleared), .irq(dout_irq)
    );

    assign out_d_idx = o_p;
    assign out_n_idx = o_n;
    assign out_u_idx = o_c;
    assign in_d_idx  = i_c;
    assign in_n_idx  = i_n;
    assign in_u_idx  = i_p;

endmodule

// File: rtl/dnu_checker.sv
module dnu_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_done,
    input logic       rx_err,
    input logic       clr_req,
    input logic       out_next,
    input logic       in_next,
    input logic       fetch,
    input logic       freeze,
    input logic [1:0] out_d_idx,
    input logic [1:0] out_n_idx,
    input logic [1:0] out_u_idx,
    input logic       out_new,
    input logic       out_reply_vld,
    input logic [1:0] out_reply_code,
    input logic       dout_irq,
    input logic [1:0] in_d_idx,
    input logic [1:0] in_n_idx,
    input logic [1:0] in_u_idx,
    input logic       in_new
);

    // R11: roles form a permutation of the three buffers
    p_out_perm_r11: assert property (@(posedge clk) disable iff (rst)
        out_d_idx != 2'd0 && out_n_idx != 2'd0 && out_u_idx != 2'd0 &&
        out_d_idx != out_n_idx && out_d_idx != out_u_idx && out_n_idx != out_u_idx);

    p_in_perm_r11: assert property (@(posedge clk) disable iff (rst)
        in_d_idx != 2'd0 && in_n_idx != 2'd0 && in_u_idx != 2'd0 &&
        in_d_idx != in_n_idx && in_d_idx != in_u_idx && in_n_idx != in_u_idx);

    // R2: interrupt only after a clean receipt
    p_irq_cause_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_err && !clr_req) |=> dout_irq);

    // R3: error leaves roles alone
    p_err_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_err && !clr_req && !out_next) |=>
            ($stable(out_d_idx) && $stable(out_n_idx) && $stable(out_u_idx) && !dout_irq));

    // R4: clear never interrupts
    p_clr_noirq_r4: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (!dout_irq && out_new));

    // R5: claim reply names the new U buffer
    p_claim_r5: assert property (@(posedge clk) disable iff (rst)
        (out_next && out_new) |=> (out_reply_vld && out_reply_code == out_u_idx));

    // R6: claim with nothing pending
    p_none_r6: assert property (@(posedge clk) disable iff (rst)
        (out_next && !out_new && !clr_req && !rx_done) |=>
            (out_reply_code == 2'd0 && $stable(out_u_idx)));

    // R7: publish marks input N fresh
    p_in_pub_r7: assert property (@(posedge clk) disable iff (rst)
        in_next |=> in_new);

    // R9: freeze blocks the fetch
    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (fetch && freeze && !in_next) |=>
            ($stable(in_d_idx) && $stable(in_n_idx) && $stable(in_new)));

endmodule

bind dnu_buffer_mgr dnu_checker u_chk (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_err(rx_err), .clr_req(clr_req),
    .out_next(out_next), .in_next(in_next), .fetch(fetch), .freeze(freeze),
    .out_d_idx(out_d_idx), .out_n_idx(out_n_idx), .out_u_idx(out_u_idx),
    .out_new(out_new), .out_reply_vld(out_reply_vld), .out_reply_code(out_reply_code),
    .dout_irq(dout_irq), .in_d_idx(in_d_idx), .in_n_idx(in_n_idx),
    .in_u_idx(in_u_idx), .in_new(in_new)
);

// File: tb/dnu_buffer_mgr_test.sv
module dnu_buffer_mgr_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_done = 0, rx_err = 0, clr_req = 0, out_next = 0;
    logic in_next = 0, fetch = 0, freeze = 0;
    logic [1:0] out_d_idx, out_n_idx, out_u_idx, out_reply_code;
    logic [1:0] in_d_idx, in_n_idx, in_u_idx;
    logic out_new, out_reply_vld, out_reply_cleared, dout_irq, in_new;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int md, mn, mu, id_, in_, iu;
    int mnew, mwip, inew, rvld, rcode, rcl, mirq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dnu_buffer_mgr uut (.*);

    task automatic model_reset();
        md = 1; mn = 2; mu = 3; mnew = 1; mwip = 1;
        id_ = 1; in_ = 2; iu = 3; inew = 0;
        rvld = 0; rcode = 0; rcl = 0; mirq = 0;
    endtask

    task automatic model_step(input logic a_rx, a_er, a_cl, a_on, a_in, a_fe, a_fz);
        int t;
        rvld = a_on; rcode = 0; rcl = 0;
        if (a_on && mnew == 1) begin
            rcode = mn; rcl = mwip;
            t = mu; mu = mn; mn = t; mnew = 0;
        end
        mirq = (a_rx && !a_er && !a_cl) ? 1 : 0;
        if (a_cl || (a_rx && !a_er)) begin
            t = md; md = mn; mn = t; mnew = 1; mwip = a_cl ? 1 : 0;
        end
        if (a_fe && !a_fz && inew == 1) begin
            t = id_; id_ = in_; in_ = t; inew = 0;
        end
        if (a_in) begin
            t = iu; iu = in_; in_ = t; inew = 1;
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "out_d_idx", out_d_idx, md);
        chk(tag, "out_n_idx", out_n_idx, mn);
        chk(tag, "out_u_idx", out_u_idx, mu);
        chk(tag, "out_new", out_new, mnew);
        chk(tag, "out_reply_vld", out_reply_vld, rvld);
        chk(tag, "out_reply_code", out_reply_code, rcode);
        chk(tag, "out_reply_cleared", out_reply_cleared, rcl);
        chk(tag, "dout_irq", dout_irq, mirq);
        chk(tag, "in_d_idx", in_d_idx, id_);
        chk(tag, "in_n_idx", in_n_idx, in_);
        chk(tag, "in_u_idx", in_u_idx, iu);
        chk(tag, "in_new", in_new, inew);
    endtask

    // drive at negedge, let one rising edge act, compare at the next negedge
    task automatic step(input logic a_rx, a_er, a_cl, a_on, a_in, a_fe, a_fz, input string tag);
        rx_done = a_rx; rx_err = a_er; clr_req = a_cl; out_next = a_on;
        in_next = a_in; fetch = a_fe; freeze = a_fz;
        @(posedge clk);
        model_step(a_rx, a_er, a_cl, a_on, a_in, a_fe, a_fz);
        @(negedge clk);
        rx_done = 0; rx_err = 0; clr_req = 0; out_next = 0;
        in_next = 0; fetch = 0; freeze = 0;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");

        //       rx er cl on in fe fz
        step(0, 0, 0, 1, 0, 0, 0, "R5");   // claim cleared power-up buffer
        step(0, 0, 0, 1, 0, 0, 0, "R6");   // nothing pending: none
        step(1, 0, 0, 0, 0, 0, 0, "R2");   // clean receipt
        step(0, 0, 0, 0, 0, 0, 0, "R2");   // interrupt gone again
        step(1, 1, 0, 0, 0, 0, 0, "R3");   // receipt with error
        step(0, 1, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, 0, "R5");   // claim received data, not cleared
        step(1, 0, 1, 0, 0, 0, 0, "R4");   // clear wins over receipt
        step(1, 0, 0, 1, 0, 0, 0, "R10");  // claim cleared buffer while receiving
        step(0, 0, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 0, 0, "R7");   // application publishes input
        step(0, 0, 0, 0, 0, 1, 1, "R9");   // frozen fetch
        step(0, 0, 0, 0, 0, 1, 0, "R8");   // real fetch
        step(0, 0, 0, 0, 0, 1, 0, "R8");   // fetch with nothing new
        step(0, 0, 0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 1, 0, "R10");  // fetch and publish together

        seed = $urandom(32'd2024);
        for (int k = 0; k < 4000; k++) begin
            step($urandom_range(0, 99) < 35, $urandom_range(0, 99) < 12,
                 $urandom_range(0, 99) < 6,  $urandom_range(0, 99) < 35,
                 $urandom_range(0, 99) < 35, $urandom_range(0, 99) < 40,
                 $urandom_range(0, 99) < 20, "R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule